// File: doc/BRIEF.md
# I/Q Direct-Sequence Despreading Correlator

This block is the acquisition and despreading stage of a direct-sequence spread-spectrum receiver. It takes one pair of low-pass-filtered in-phase and quadrature samples per handshake. It pushes each component into its own delay line. It then correlates both delay lines against one fixed pseudo-noise chip sequence that is held on chip. The two correlation sums give a non-coherent detection metric, |I|+|Q|, which is compared against a fixed threshold.

When the metric reaches the threshold, the block raises its detect flag and captures the two correlation sums. The captured in-phase value is the recovered data. The captured quadrature value is the output sample. Their signed product is the phase-error term for the carrier-tracking loop. When the metric stays below the threshold, the captured values keep their previous contents. The mixer, the loop filters and the oscillator sit outside this block.

Samples enter over a valid/ready handshake. The block holds `s_ready` low while it works on a sample, and an upstream source must keep its data until the handshake completes. Results leave as plain registered levels with a one-cycle `res_valid` strobe. The output side cannot be back-pressured.

Top module: `iq_despreader`

## Requirements
- R1: A sample pair is accepted on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` goes low on the next cycle and stays low until the result strobe. Values presented while `s_ready` is low are ignored.
- R2: Each channel keeps the last CODE_LEN (default 135 = 15*9) accepted samples. Position 0 holds the newest sample. Reset clears every position to zero, and a sample leaves the line after CODE_LEN further pushes.
- R3: Chip k is taken from a 7-bit register s. For chip 0, s starts at PN_SEED (default 7'h5B). Chip k is bit 0 of s at step k, and the next state is {s[0]^s[1], s[6:1]}. A bit value of 1 weighs +1 and a bit value of 0 weighs -1. Each correlation is the exact signed sum over k of weight(k) times sample[k]. It is reported as a 24-bit signed value with no truncation.
- R4: `det` is 1 exactly when |corr_I| + |corr_Q| >= THRESH (default 17100). Otherwise `det` is 0. The value 17099 gives 0 and the value 17100 gives 1.
- R5: `dat_i` and `dat_q` take the new correlation sums only for a sample whose `det` is 1. Otherwise they hold their previous values.
- R6: `loop_err` always equals the signed 48-bit product `dat_i * dat_q`.
- R7: `res_valid` pulses for one cycle, CODE_LEN+1 cycles after the accepting edge. `det`, `dat_i` and `dat_q` change only on that edge, and `s_ready` is high again in that cycle.
- R8: After reset, `s_ready` is 1 and `res_valid`, `det`, `dat_i`, `dat_q` and `loop_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample pair present |
| s_ready | output | 1 | Block can take a sample pair |
| s_i | input | 16 | In-phase sample, signed |
| s_q | input | 16 | Quadrature sample, signed |
| res_valid | output | 1 | One-cycle strobe: result of the last sample is ready |
| det | output | 1 | Detection metric reached the threshold on the last sample |
| dat_i | output | 24 | Captured in-phase correlation (recovered data), signed |
| dat_q | output | 24 | Captured quadrature correlation (output sample), signed |
| loop_err | output | 48 | Carrier-loop error, dat_i times dat_q, signed |

## Verification
Every result is due 136 cycles (CODE_LEN+1) after the edge that accepted the sample. The bench counts falling edges from that accepting edge until it sees `res_valid`, and checks that the count is exactly 136. It then compares `det`, `dat_i`, `dat_q` and `loop_err` at that same falling edge against its own delay-line and chip model. While a sample is being processed, the bench often drives junk data with `s_valid` high. Because every later result still matches the model, this shows the junk was never taken. The bench also checks that `s_ready` is low one cycle after acceptance.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int LFSR_W = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_t;

  // One step of the chip generator: shift right, feedback into the top bit.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[1], s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/corr_delay.sv
// Sample history of one channel; index 0 is the newest entry.
module corr_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 135,
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic signed [W-1:0] din,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic signed [W-1:0] rd_data
);
  logic signed [W-1:0] line [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) line[k] <= '0;
    end else if (push) begin
      line[0] <= din;
      for (int k = 1; k < DEPTH; k++) line[k] <= line[k-1];
    end
  end

  assign rd_data = line[rd_idx];
endmodule

// File: rtl/corr_mac.sv
// Serial accumulator: adds or subtracts one sample per enabled cycle.
module corr_mac #(
  parameter int W     = 16,
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    en,
  input  logic                    chip,
  input  logic signed [W-1:0]     sample,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] ext;

  assign ext = {{(ACC_W-W){sample[W-1]}}, sample};

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (en)     acc <= chip ? acc + ext : acc - ext;
  end
endmodule

// File: rtl/corr_detect.sv
// Non-coherent metric, threshold compare and conditional capture.
module corr_detect #(
  parameter int CW     = 24,
  parameter int THRESH = 17100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eval,
  input  logic signed [CW-1:0]   ci,
  input  logic signed [CW-1:0]   cq,
  output logic                   det,
  output logic signed [CW-1:0]   lat_i,
  output logic signed [CW-1:0]   lat_q,
  output logic signed [2*CW-1:0] loop_err
);
  localparam int MW = CW + 2;

  logic [CW:0]   mag_i, mag_q;
  logic [MW-1:0] metric;
  logic          hit;

  assign mag_i  = ci[CW-1] ? -{ci[CW-1], ci} : {ci[CW-1], ci};
  assign mag_q  = cq[CW-1] ? -{cq[CW-1], cq} : {cq[CW-1], cq};
  assign metric = {1'b0, mag_i} + {1'b0, mag_q};
  assign hit    = metric >= MW'(THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det   <= 1'b0;
      lat_i <= '0;
      lat_q <= '0;
    end else if (eval) begin
      det <= hit;
      if (hit) begin
        lat_i <= ci;
        lat_q <= cq;
      end
    end
  end

  assign loop_err = lat_i * lat_q;
endmodule

// File: rtl/iq_despreader.sv
module iq_despreader #(
  parameter int          SAMPLE_W = 16,
  parameter int          CODE_LEN = 135,
  parameter int          THRESH   = 17100,
  parameter logic [6:0]  PN_SEED  = 7'h5B
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             s_valid,
  output logic                                             s_ready,
  input  logic signed [SAMPLE_W-1:0]                       s_i,
  input  logic signed [SAMPLE_W-1:0]                       s_q,
  output logic                                             res_valid,
  output logic                                             det,
  output logic signed [SAMPLE_W+$clog2(CODE_LEN)-1:0]      dat_i,
  output logic signed [SAMPLE_W+$clog2(CODE_LEN)-1:0]      dat_q,
  output logic signed [2*(SAMPLE_W+$clog2(CODE_LEN))-1:0]  loop_err
);
  import corr_pkg::*;

  localparam int IDX_W  = $clog2(CODE_LEN);
  localparam int CORR_W = SAMPLE_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CODE_LEN - 1);

  function automatic logic [CODE_LEN-1:0] build_pn();
    logic [LFSR_W-1:0]   s;
    logic [CODE_LEN-1:0] code;
    s = PN_SEED;
    for (int k = 0; k < CODE_LEN; k++) begin
      code[k] = s[0];
      s = lfsr_step(s);
    end
    return code;
  endfunction

  localparam logic [CODE_LEN-1:0] PN_CODE = build_pn();

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic              accept;
  logic              chip;

  logic signed [SAMPLE_W-1:0] ch_in  [2];
  logic signed [SAMPLE_W-1:0] ch_tap [2];
  logic signed [CORR_W-1:0]   ch_sum [2];

  assign s_ready  = (state == ST_IDLE);
  assign accept   = s_valid && s_ready;
  assign chip     = PN_CODE[idx];
  assign ch_in[0] = s_i;
  assign ch_in[1] = s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          idx   <= '0;
        end
        ST_RUN: begin
          if (idx == LAST) state <= ST_DONE;
          else             idx   <= idx + 1'b1;
        end
        ST_DONE: begin
          state     <= ST_IDLE;
          res_valid <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    corr_delay #(.W(SAMPLE_W), .DEPTH(CODE_LEN), .IDX_W(IDX_W)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (accept),
      .din     (ch_in[ch]),
      .rd_idx  (idx),
      .rd_data (ch_tap[ch])
    );

    corr_mac #(.W(SAMPLE_W), .ACC_W(CORR_W)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .en     (state == ST_RUN),
      .chip   (chip),
      .sample (ch_tap[ch]),
      .acc    (ch_sum[ch])
    );
  end

  corr_detect #(.CW(CORR_W), .THRESH(THRESH)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .eval     (state == ST_DONE),
    .ci       (ch_sum[0]),
    .cq       (ch_sum[1]),
    .det      (det),
    .lat_i    (dat_i),
    .lat_q    (dat_q),
    .loop_err (loop_err)
  );
endmodule

// File: rtl/iq_despreader_chk.sv
module iq_despreader_chk #(
  parameter int CORR_W   = 24,
  parameter int CODE_LEN = 135
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     s_valid,
  input logic                     s_ready,
  input logic                     res_valid,
  input logic                     det,
  input logic signed [CORR_W-1:0] dat_i,
  input logic signed [CORR_W-1:0] dat_q,
  input logic signed [2*CORR_W-1:0] loop_err
);
  // Cycles since acceptance: 1 after the accepting edge.
  logic [15:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)                   since <= '0;
    else if (s_valid && s_ready)  since <= 16'd1;
    else if (since != 16'hFFFF && since != 16'd0) since <= since + 16'd1;
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_det_only_on_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(det) |-> res_valid);

  assert_hold_unless_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dat_i) || !$stable(dat_q)) |-> (res_valid && det));

  assert_zero_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_i == '0 || dat_q == '0) |-> (loop_err == '0));

  assert_err_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_i != '0 && dat_q != '0) |-> (loop_err[2*CORR_W-1] == (dat_i[CORR_W-1] ^ dat_q[CORR_W-1])));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_ready_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> s_ready);

  // Strobe becomes visible CODE_LEN+1 edges after acceptance; counter then reads CODE_LEN+2.
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (since == 16'(CODE_LEN + 2)));
endmodule

bind iq_despreader iq_despreader_chk #(.CORR_W(CORR_W), .CODE_LEN(CODE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .res_valid (res_valid),
  .det       (det),
  .dat_i     (dat_i),
  .dat_q     (dat_q),
  .loop_err  (loop_err)
);

// File: tb/iq_despreader_test.sv
module iq_despreader_test;
  localparam int N  = 135;
  localparam int TH = 17100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic s_ready, res_valid, det;
  logic signed [23:0] dat_i, dat_q;
  logic signed [47:0] loop_err;

  always #2 clk = ~clk;

  iq_despreader uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .res_valid(res_valid), .det(det),
    .dat_i(dat_i), .dat_q(dat_q), .loop_err(loop_err)
  );

  int tests = 0, fails = 0;
  int hi [N];
  int hq [N];
  int wt [N];
  longint li = 0, lq = 0;
  bit edet = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint corr_of(input bit use_q);
    longint s = 0;
    for (int k = 0; k < N; k++) s += wt[k] * (use_q ? hq[k] : hi[k]);
    return s;
  endfunction

  function automatic longint absl(input longint v);
    return v < 0 ? -v : v;
  endfunction

  // Push one pair; junk>0 keeps s_valid high with junk data for that many busy cycles.
  task automatic push_sample(input int vi, input int vq, input int junk);
    longint ci, cq;
    int lat;
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_i = 16'(vi); s_q = 16'(vq);
    @(negedge clk);
    if (junk > 0) begin s_i = 16'($urandom); s_q = 16'($urandom); end
    else s_valid = 1'b0;
    for (int k = N-1; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
    hi[0] = vi; hq[0] = vq;
    ci = corr_of(0); cq = corr_of(1);
    edet = (absl(ci) + absl(cq)) >= TH;
    if (edet) begin li = ci; lq = cq; end
    lat = 0;
    while (!res_valid) begin
      @(negedge clk);
      lat++;
      if (lat == 1) check(s_ready == 1'b0, "R1", "ready low while busy", s_ready, 0);
      if (lat == junk) s_valid = 1'b0;
    end
    s_valid = 1'b0;
    check(lat == N + 1, "R7", "result latency", lat, N + 1);
    check(det == edet, "R4", "detect flag", det, edet);
    check(dat_i == li, "R5", "captured I", dat_i, li);
    check(dat_q == lq, "R5", "captured Q", dat_q, lq);
    check(loop_err == li * lq, "R6", "loop error", loop_err, li * lq);
  endtask

  initial begin
    bit [6:0] s;
    void'($urandom(32'd20240611));
    s = 7'h5B;
    for (int k = 0; k < N; k++) begin
      wt[k] = s[0] ? 1 : -1;
      s = {s[0] ^ s[1], s[6:1]};
      hi[k] = 0; hq[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(s_ready == 1'b1, "R8", "reset ready", s_ready, 1);
    check(res_valid == 1'b0, "R8", "reset res_valid", res_valid, 0);
    check(det == 1'b0, "R8", "reset det", det, 0);
    check(dat_i == 0 && dat_q == 0, "R8", "reset captured", dat_i, 0);
    check(loop_err == 0, "R8", "reset loop_err", loop_err, 0);

    // R2: history starts at zero, so the first result is weight(0)*20000 alone.
    push_sample(20000, 0, 0);
    check(dat_i == wt[0] * 20000, "R2", "first sample alone", dat_i, wt[0] * 20000);
    // R2: the sample stays for N pushes, then leaves.
    for (int n = 1; n < N; n++) push_sample(0, 0, 0);
    check(det == 1'b1, "R2", "oldest still present", det, 1);
    push_sample(0, 0, 0);
    check(det == 1'b0, "R2", "sample shifted out", det, 0);
    check(dat_i == wt[N-1] * 20000, "R5", "held after miss", dat_i, wt[N-1] * 20000);

    // R4: threshold boundary, 17099 misses and 17100 hits.
    push_sample(17099, 0, 0);
    check(det == 1'b0, "R4", "metric 17099", det, 0);
    push_sample(0, 1, 0);
    check(det == 1'b1, "R4", "metric 17100", det, 1);

    // R3: code-matched burst gives 150*N on I and -100*N on Q.
    for (int j = 0; j < N; j++) push_sample(150 * wt[N-1-j], -100 * wt[N-1-j], 0);
    check(dat_i == 150 * N, "R3", "matched I sum", dat_i, 150 * N);
    check(dat_q == -100 * N, "R3", "matched Q sum", dat_q, -100 * N);

    // Small random samples with junk during busy (R1): mostly misses, outputs hold.
    for (int n = 0; n < 120; n++)
      push_sample(int'($urandom_range(400)) - 200, int'($urandom_range(400)) - 200,
                  int'($urandom_range(120)));
    // Full-scale random samples: hits with large sums.
    for (int n = 0; n < 120; n++)
      push_sample(int'($urandom_range(65534)) - 32767, int'($urandom_range(65534)) - 32767,
                  int'($urandom_range(120)));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R7 watchdog: actual %0d cycles expected completion", 190000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule